// File: doc/BRIEF.md
# Programmable Asynchronous Memory Access Sequencer

The sequencer accepts 32-bit read and write requests from the chip side and plays each one out on an external asynchronous memory bus as one or more timed access cycles. Every cycle walks through a setup phase (address and chip select valid, strobes idle), a strobe phase (output enable or write enable low) and a hold phase, and after the last cycle of a request a turnaround gap keeps the bus quiet before the next request is taken. All phase lengths, the device width and the chip-select behaviour come from a per-chip-select configuration word that the surrounding logic supplies as a flat input bus.

A request names a chip select, a byte address (the two low bits are ignored, the request is always a full 32-bit word) and, for writes, the data. On an 8-bit device the word is moved in four byte cycles, on a 16-bit device in two halfword cycles, lowest-addressed part first. There are no byte enables on the bus, so partial-word writes do not exist at this interface. Read data is assembled internally and returned with a one-cycle done pulse.

Top module: `async_mem_seq`

## Requirements
- R1: After reset every chip select, `mem_oe_n` and `mem_we_n` are high and `req_ready` is high.
- R2: A read cycle spends r_setup+1 clocks in setup, keeps `mem_oe_n` low for exactly r_strobe+1 clocks and then spends r_hold+1 clocks in hold. In the configuration word (bit 0 first) the fields are w_setup[3:0], w_strobe[9:4], w_hold[12:10], r_setup[16:13], r_strobe[22:17], r_hold[25:23], turnaround[27:26], select_strobe[28], wide[29].
- R3: A write cycle uses w_setup, w_strobe and w_hold the same way, with `mem_we_n` low for exactly w_strobe+1 clocks.
- R4: With select_strobe=0 the selected chip select is low through setup, strobe and hold of every cycle; with select_strobe=1 it is low only during the strobe phase.
- R5: With wide=0 a request takes four back-to-back cycles with `mem_addr` = {addr[ADDR_W-1:2], beat[1:0]}; with wide=1 it takes two cycles with `mem_addr` = {1'b0, addr[ADDR_W-1:2], beat[0]}; beats run from 0 upward and the address is stable within a cycle.
- R6: Read data is sampled in the last strobe clock of each cycle into the byte (wide=0) or halfword (wide=1) lane selected by the beat; `rsp_done` is high for exactly the one clock after the last hold clock, with the assembled word on `rsp_rdata`.
- R7: During a write, `mem_dq` carries the beat's lane (upper byte zero on an 8-bit device) from the first setup clock to the last hold clock; the block never drives `mem_dq` while `mem_oe_n` is low.
- R8: After the last hold clock all strobes stay high and `req_ready` stays low for turnaround+1 clocks, then `req_ready` returns high.
- R9: The configuration is captured when a request is accepted; changing the configuration during an access has no effect on it, and the next accepted request uses the new value.
- R10: At most one chip select is low at a time, only the requested one, and `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_all | input | NUM_CS*30 | Configuration words, chip select k in bits [k*30 +: 30] |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Chip select index |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-clock pulse when a request completes |
| rsp_rdata | output | 32 | Assembled read word, valid with `rsp_done` |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W | External byte or halfword address |
| mem_dq | inout | 16 | External data bus |

## Verification
The hardest situation to reach is a configuration change that lands while an access is already in flight, because from the ports the block looks idle-or-busy and nothing tells the stimulus where the captured copy lives. The bench rewrites the configuration word one clock after acceptance, keeps checking the running access against the old timing cycle by cycle, and then issues a second request whose phase lengths must follow the new word. Minimum timings (all fields zero) on an 8-bit device in select-strobe mode exercise one-clock phases with four beats back to back.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
  localparam int SETUP_W  = 4;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 3;
  localparam int TA_W     = 2;
  localparam int CNT_W    = STROBE_W;
  localparam int WORD_W   = 32;
  localparam int DQ_W     = 16;

  // Bit 0 of the configuration word is w_setup[0].
  typedef struct packed {
    logic                wide;
    logic                sel_strobe;
    logic [TA_W-1:0]     ta;
    logic [HOLD_W-1:0]   r_hold;
    logic [STROBE_W-1:0] r_strobe;
    logic [SETUP_W-1:0]  r_setup;
    logic [HOLD_W-1:0]   w_hold;
    logic [STROBE_W-1:0] w_strobe;
    logic [SETUP_W-1:0]  w_setup;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_TURN
  } phase_e;

  // Counter preload for a phase: field value = clocks minus one.
  function automatic logic [CNT_W-1:0] phase_cnt(cfg_t c, logic wr, phase_e p);
    case (p)
      PH_SETUP:  return wr ? CNT_W'(c.w_setup)  : CNT_W'(c.r_setup);
      PH_STROBE: return wr ? CNT_W'(c.w_strobe) : CNT_W'(c.r_strobe);
      PH_HOLD:   return wr ? CNT_W'(c.w_hold)   : CNT_W'(c.r_hold);
      PH_TURN:   return CNT_W'(c.ta);
      default:   return '0;
    endcase
  endfunction

  // Index of the final beat for a 32-bit word.
  function automatic logic [1:0] last_beat(logic wide);
    return wide ? 2'd1 : 2'd3;
  endfunction
endpackage

// File: rtl/amseq_timer.sv
module amseq_timer
  import amseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cfg_t       cfg,
  input  logic       wr,
  output phase_e     phase,
  output logic [1:0] beat,
  output logic       strobe_last,
  output logic       done
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign strobe_last = (phase == PH_STROBE) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      beat  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= phase_cnt(cfg, wr, PH_SETUP);
          beat  <= '0;
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_STROBE;
          cnt   <= phase_cnt(cfg, wr, PH_STROBE);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt_zero) begin
          phase <= PH_HOLD;
          cnt   <= phase_cnt(cfg, wr, PH_HOLD);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          if (beat == last_beat(cfg.wide)) begin
            phase <= PH_TURN;
            cnt   <= phase_cnt(cfg, wr, PH_TURN);
            done  <= 1'b1;
          end else begin
            phase <= PH_SETUP;
            cnt   <= phase_cnt(cfg, wr, PH_SETUP);
            beat  <= beat + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        PH_TURN: if (cnt_zero) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amseq_lane.sv
module amseq_lane
  import amseq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic [ADDR_W-3:0] word_addr,
  input  logic [1:0]        beat,
  input  logic [WORD_W-1:0] wdata,
  input  logic              capture,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DQ_W-1:0]   dq_out,
  output logic [WORD_W-1:0] rdata
);
  localparam int HALF_W = DQ_W;
  localparam int BYTE_W = DQ_W / 2;

  assign ext_addr = wide ? {1'b0, word_addr, beat[0]} : {word_addr, beat};
  assign dq_out   = wide ? wdata[beat[0]*HALF_W +: HALF_W]
                         : {{BYTE_W{1'b0}}, wdata[beat*BYTE_W +: BYTE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (capture) begin
      if (wide) rdata[beat[0]*HALF_W +: HALF_W] <= dq_in;
      else      rdata[beat*BYTE_W +: BYTE_W]    <= dq_in[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
  import amseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CS*CFG_W-1:0] cfg_all,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_done,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [ADDR_W-1:0]       mem_addr,
  inout  wire  [DQ_W-1:0]         mem_dq
);
  cfg_t              cfg_arr [NUM_CS];
  cfg_t              cfg_q, cfg_run;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-3:0] word_q;
  logic [WORD_W-1:0] wdata_q;
  logic              wr_q, wr_run;
  logic              accept;
  phase_e            ph;
  logic [1:0]        beat;
  logic              strobe_last;
  logic              in_cycle, cs_on, dq_oe;
  logic [DQ_W-1:0]   dq_out;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    assign cfg_arr[g] = cfg_t'(cfg_all[g*CFG_W +: CFG_W]);
  end

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign cfg_run   = accept ? cfg_arr[req_cs] : cfg_q;
  assign wr_run    = accept ? req_write : wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cs_q    <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      cfg_q   <= cfg_arr[req_cs];
      cs_q    <= req_cs;
      word_q  <= req_addr[ADDR_W-1:2];
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  amseq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .cfg(cfg_run), .wr(wr_run),
    .phase(ph), .beat(beat), .strobe_last(strobe_last), .done(rsp_done)
  );

  amseq_lane #(.ADDR_W(ADDR_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .wide(cfg_q.wide), .word_addr(word_q),
    .beat(beat), .wdata(wdata_q), .capture(strobe_last && !wr_q),
    .dq_in(mem_dq), .ext_addr(mem_addr), .dq_out(dq_out), .rdata(rsp_rdata)
  );

  assign in_cycle = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  assign cs_on    = cfg_q.sel_strobe ? (ph == PH_STROBE) : in_cycle;
  assign mem_oe_n = !((ph == PH_STROBE) && !wr_q);
  assign mem_we_n = !((ph == PH_STROBE) &&  wr_q);
  assign dq_oe    = in_cycle && wr_q;
  assign mem_dq   = dq_oe ? dq_out : 'z;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_n[g] = !(cs_on && (cs_q == CS_W'(g)));
  end
endmodule

// File: rtl/amseq_checks.sv
module amseq_checks
  import amseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              ss,
  input logic [NUM_CS-1:0] cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              ready,
  input logic              done,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);
  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  assert_ss_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ss && phase != PH_STROBE) |-> (&cs_n));
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE || phase == PH_HOLD) |-> $stable(addr));
  assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  assert_done_after_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(phase == PH_HOLD));
  assert_turn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> (&cs_n && oe_n && we_n && !ready));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (&cs_n && oe_n && we_n));
endmodule

bind async_mem_seq amseq_checks #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .phase(ph), .ss(cfg_q.sel_strobe),
  .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .ready(req_ready),
  .done(rsp_done), .dq_oe(dq_oe), .addr(mem_addr)
);

// File: tb/async_mem_seq_test.sv
module async_mem_seq_test;
  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int CW  = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCS*CW-1:0] cfg_all = '0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]      req_cs = '0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            req_ready, rsp_done;
  logic [31:0]     rsp_rdata;
  logic [NCS-1:0]  mem_cs_n;
  logic            mem_oe_n, mem_we_n;
  logic [AW-1:0]   mem_addr;
  wire  [15:0]     mem_dq;
  int              tests = 0, fails = 0;
  bit              finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] rd_pat(logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
  endfunction

  assign mem_dq = !mem_oe_n ? rd_pat(mem_addr) : 16'hzzzz;

  async_mem_seq #(.NUM_CS(NCS), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_all(cfg_all), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  function automatic logic [29:0] mk_cfg(int ws, int wt, int wh, int rs, int rt,
                                         int rh, int ta, bit ss, bit wide);
    logic [29:0] c = '0;
    c[3:0] = 4'(ws);  c[9:4] = 6'(wt);  c[12:10] = 3'(wh);
    c[16:13] = 4'(rs); c[22:17] = 6'(rt); c[25:23] = 3'(rh);
    c[27:26] = 2'(ta); c[28] = ss; c[29] = wide;
    return c;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Issues one request and checks every clock until req_ready returns.
  task automatic run_access(int cs, bit wr, logic [AW-1:0] addr, logic [31:0] wd,
                            logic [29:0] cfg, logic [29:0] cfg_late, bit late);
    int s, t, h, ta, L, nb, endi, b, o;
    bit ss, wide, strobe, inbeat, on;
    logic [31:0] exp_rd = '0;
    logic [AW-1:0] ea;
    logic [NCS-1:0] exp_cs;
    string rq;
    s  = wr ? int'(cfg[3:0])  : int'(cfg[16:13]);
    t  = wr ? int'(cfg[9:4])  : int'(cfg[22:17]);
    h  = wr ? int'(cfg[12:10]) : int'(cfg[25:23]);
    ta = int'(cfg[27:26]); ss = cfg[28]; wide = cfg[29];
    L = s + t + h + 3; nb = wide ? 2 : 4; endi = nb * L + ta + 1;
    rq = late ? "R9" : (wr ? "R3" : "R2");
    for (int k = 0; k < nb; k++) begin
      ea = wide ? {1'b0, addr[AW-1:2], 1'(k)} : {addr[AW-1:2], 2'(k)};
      if (wide) exp_rd[k*16 +: 16] = rd_pat(ea);
      else      exp_rd[k*8 +: 8]   = rd_pat(ea)[7:0];
    end
    cfg_all[cs*CW +: CW] = cfg;
    req_cs = 2'(cs); req_write = wr; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= endi; i++) begin
      if (late && i == 1) cfg_all[cs*CW +: CW] = cfg_late;
      inbeat = (i < nb * L);
      b = i / L; o = i % L;
      strobe = inbeat && (o > s) && (o <= s + t + 1);
      on = ss ? strobe : inbeat;
      exp_cs = on ? ~(NCS'(1) << cs) : '1;
      chk(rq, "oe_n", 32'(mem_oe_n), 32'(!(strobe && !wr)));
      chk(rq, "we_n", 32'(mem_we_n), 32'(!(strobe && wr)));
      chk(inbeat ? "R4" : "R10", "cs_n", 32'(mem_cs_n), 32'(exp_cs));
      if (inbeat) begin
        ea = wide ? {1'b0, addr[AW-1:2], 1'(b)} : {addr[AW-1:2], 2'(b)};
        chk("R5", "addr", 32'(mem_addr), 32'(ea));
        if (wr) chk("R7", "dq", 32'(mem_dq),
                    wide ? 32'(wd[b*16 +: 16]) : 32'(wd[b*8 +: 8]));
      end
      chk("R6", "done", 32'(rsp_done), 32'(i == nb * L));
      if (!wr && i == nb * L) chk("R6", "rdata", rsp_rdata, exp_rd);
      chk("R8", "ready", 32'(req_ready), 32'(i == endi));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1", "cs_n", 32'(mem_cs_n), 32'hF);
    chk("R1", "oe_n", 32'(mem_oe_n), 32'h1);
    chk("R1", "we_n", 32'(mem_we_n), 32'h1);
    chk("R1", "ready", 32'(req_ready), 32'h1);
  endtask

  task automatic t_read16;
    logic [29:0] c = mk_cfg(0, 0, 0, 1, 2, 0, 1, 1'b0, 1'b1);
    run_access(1, 1'b0, 24'h00_1234, 32'h0, c, c, 1'b0);
  endtask

  task automatic t_write16;
    logic [29:0] c = mk_cfg(0, 3, 1, 2, 2, 2, 2, 1'b0, 1'b1);
    run_access(2, 1'b1, 24'h0A_0010, 32'hCAFE_F00D, c, c, 1'b0);
  endtask

  task automatic t_read8_ss;
    logic [29:0] c = mk_cfg(1, 1, 1, 2, 1, 1, 0, 1'b1, 1'b0);
    run_access(0, 1'b0, 24'h00_0A0F, 32'h0, c, c, 1'b0);
  endtask

  task automatic t_write8_min;
    logic [29:0] c = mk_cfg(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    run_access(3, 1'b1, 24'h12_3454, 32'h8844_22AA, c, c, 1'b0);
  endtask

  task automatic t_long_strobe;
    logic [29:0] c = mk_cfg(15, 63, 7, 15, 63, 7, 3, 1'b0, 1'b1);
    run_access(1, 1'b1, 24'h00_0004, 32'h1357_9BDF, c, c, 1'b0);
  endtask

  task automatic t_cfg_change;
    logic [29:0] c0 = mk_cfg(1, 1, 1, 1, 3, 1, 1, 1'b0, 1'b1);
    logic [29:0] c1 = mk_cfg(2, 2, 0, 0, 0, 2, 0, 1'b1, 1'b0);
    run_access(2, 1'b0, 24'h00_5550, 32'h0, c0, c1, 1'b1);
    run_access(2, 1'b0, 24'h00_6660, 32'h0, c1, c1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read16();
    t_write16();
    t_read8_ss();
    t_write8_min();
    t_long_strobe();
    t_cfg_change();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule